// File: doc/BRIEF.md
# Snoop Inquire Controller

This block sits on the system side of a write-back caching processor. It turns the address strobe of another bus master into an inquire (snoop) request to the processor, and it follows the processor's answer through to the end of any write-back of a modified line. A request is passed on in the same clock as the master's strobe, but only when the processor's bus is quiet. The bus is quiet when address-hold or HOLD is asserted, or in the exact clock in which HOLD is released. A request in the clock after a HOLD release is dropped. A request made while the processor is in its built-in self-test is also dropped.

Each accepted inquire has its address captured. If address-hold is still asserted when the processor strobes the write-back, the processor is not driving the address bus. In that case the block supplies the captured address on its write-back address output. If address-hold was released earlier, the processor's own address is passed through. An inquire can hit the line of a write-back the processor has already started for replacement or flush. The block then flags that burst as the answer to the snoop and waits for that burst to finish, not for a new one. A branch-trace special cycle has its address bits 31..3 captured at the processor's strobe.

Top module: `snp_inquire_ctrl`

## Requirements
- R1: `eads_o` is high in a clock only when `mst_ads_i` is high and one of the following holds: `ahold_i` is high, `hold_i` is high, or `hold_i` went from high in the previous clock to low in this one. When `hold_i` fell in the previous clock and is still low, `eads_o` stays low even if `ahold_i` is high.
- R2: When `ahold_i` stays high from the inquire until the processor's write-back strobe, `wb_latched_o` is 1 and `wb_addr_o` equals the captured inquire address. This holds at that strobe and through the burst that follows.
- R3: When `ahold_i` falls between the inquire and the write-back strobe, `wb_latched_o` is 0 and `wb_addr_o` follows `cpu_addr_i`. Whenever `busy_o` is 0, `wb_latched_o` is 0.
- R4: After a hit-modified answer, no further `eads_o` is produced while the write-back burst of BEATS `cpu_brdy_i` beats runs, including during its last beat. A new `eads_o` is accepted in the first clock after the last beat in which `cpu_hitm_i` is low.
- R5: `cpu_hitm_i` is sampled LOOK_LAT clocks after the clock of `eads_o`. If it is low there, `busy_o` drops on the next clock.
- R6: An inquire whose address bits above LINE_W match the line of a write-back burst already running (started by `cpu_ads_i` with `cpu_wbk_i` high) sets `join_o` on the next clock. With a hit-modified answer, the block completes when that burst's last beat has been seen and `cpu_hitm_i` is low, with no further strobe. `wb_latched_o` stays 0 throughout.
- R7: On `cpu_ads_i` with `cpu_btm_i` high, `btm_addr_o` takes `cpu_addr_i[31:3]` on the next clock. A strobe without `cpu_btm_i` leaves `btm_addr_o` unchanged.
- R8: After `cpu_reset_i` falls while `cpu_init_i` is high, `eads_o` stays low until the processor issues its first `cpu_ads_i`. From the clock after that strobe, inquires are accepted again.
- R9: Synchronous active-high `rst` clears `busy_o`, `join_o`, `wb_latched_o`, `btm_addr_o` and the captured address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mst_ads_i | input | 1 | Address strobe of the other caching master |
| mst_addr_i | input | AW | Address of the other master's access |
| hold_i | input | 1 | HOLD as driven to the processor |
| ahold_i | input | 1 | Address-hold as driven to the processor |
| cpu_reset_i | input | 1 | Processor RESET pin |
| cpu_init_i | input | 1 | Processor INIT pin |
| cpu_ads_i | input | 1 | Processor address strobe |
| cpu_wbk_i | input | 1 | Qualifier: the current strobe starts a write-back burst |
| cpu_btm_i | input | 1 | Qualifier: the current strobe is a branch-trace special cycle |
| cpu_addr_i | input | AW | Processor address bus |
| cpu_brdy_i | input | 1 | Burst-ready from memory |
| cpu_hitm_i | input | 1 | Processor hit-modified response |
| eads_o | output | 1 | Inquire request to the processor |
| busy_o | output | 1 | An inquire is outstanding |
| join_o | output | 1 | Running write-back counts as the snoop's answer |
| wb_latched_o | output | 1 | Write-back address comes from the captured copy |
| wb_addr_o | output | AW | Write-back address for the memory side |
| btm_addr_o | output | AW-3 | Captured branch-trace address bits 31..3 |

## Verification
The properties assume the processor behaves at its pins as described. Every write-back strobe carries `cpu_wbk_i`. Exactly BEATS burst-ready beats follow each write-back strobe. `cpu_hitm_i` is low in the clock after the last beat. No processor strobe coincides with a burst-ready. The bench drives only such sequences. It raises hit-modified exactly LOOK_LAT clocks after an inquire and drops it right after the last beat. It also keeps the other master's strobe low in the clocks where a real master could not run, except where a test deliberately probes a forbidden window.

// File: rtl/snp_inquire_pkg.sv
package snp_inquire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WAIT_ADS,
        ST_BURST,
        ST_JOIN,
        ST_DRAIN
    } snp_state_e;

endpackage

// File: rtl/snp_window.sv
module snp_window (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic ahold_i,
    input  logic cpu_reset_i,
    input  logic cpu_init_i,
    input  logic cpu_ads_i,
    output logic win_ok_o
);

    typedef struct packed {
        logic hold;
        logic rel;
        logic creset;
        logic bist;
    } win_reg_t;

    win_reg_t q, d;

    always_comb begin
        d        = q;
        d.hold   = hold_i;
        d.rel    = q.hold & ~hold_i;
        d.creset = cpu_reset_i;
        if (q.creset && !cpu_reset_i && cpu_init_i) begin
            d.bist = 1'b1;
        end else if (cpu_ads_i) begin
            d.bist = 1'b0;
        end
        win_ok_o = (ahold_i | hold_i | (q.hold & ~hold_i))
                 & ~(q.rel & ~hold_i)
                 & ~q.bist;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/snp_burst.sv
module snp_burst #(
    parameter int AW     = 32,
    parameter int LINE_W = 5,
    parameter int BEATS  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_ads_i,
    input  logic                 cpu_wbk_i,
    input  logic [AW-LINE_W-1:0] ads_line_i,
    input  logic                 cpu_brdy_i,
    output logic                 run_o,
    output logic                 last_o,
    output logic [AW-LINE_W-1:0] line_o
);

    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        logic                 run;
        logic [BW-1:0]        beat;
        logic [AW-LINE_W-1:0] line;
    } burst_reg_t;

    burst_reg_t q, d;

    always_comb begin
        d      = q;
        last_o = q.run & cpu_brdy_i & (q.beat == LAST_BEAT);
        if (cpu_ads_i && cpu_wbk_i) begin
            d.run  = 1'b1;
            d.beat = '0;
            d.line = ads_line_i;
        end else if (q.run && cpu_brdy_i) begin
            if (q.beat == LAST_BEAT) begin
                d.run = 1'b0;
            end else begin
                d.beat = q.beat + 1'b1;
            end
        end
        run_o  = q.run;
        line_o = q.line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/snp_inquire_ctrl.sv
module snp_inquire_ctrl
    import snp_inquire_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LINE_W   = 5,
    parameter int BEATS    = 4,
    parameter int LOOK_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mst_ads_i,
    input  logic [AW-1:0] mst_addr_i,
    input  logic          hold_i,
    input  logic          ahold_i,
    input  logic          cpu_reset_i,
    input  logic          cpu_init_i,
    input  logic          cpu_ads_i,
    input  logic          cpu_wbk_i,
    input  logic          cpu_btm_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic          cpu_brdy_i,
    input  logic          cpu_hitm_i,
    output logic          eads_o,
    output logic          busy_o,
    output logic          join_o,
    output logic          wb_latched_o,
    output logic [AW-1:0] wb_addr_o,
    output logic [AW-4:0] btm_addr_o
);

    localparam int CW = (LOOK_LAT > 1) ? $clog2(LOOK_LAT) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(LOOK_LAT - 1);

    typedef struct packed {
        snp_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] inq_addr;
        logic          kept;
        logic          use_cp;
        logic          joined;
        logic [AW-4:0] btm;
    } ctl_reg_t;

    ctl_reg_t q, d;

    logic                 win_ok;
    logic                 wb_run;
    logic                 wb_last;
    logic [AW-LINE_W-1:0] wb_line;
    logic                 free_now;
    logic                 line_hit;

    snp_window u_window (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (hold_i),
        .ahold_i    (ahold_i),
        .cpu_reset_i(cpu_reset_i),
        .cpu_init_i (cpu_init_i),
        .cpu_ads_i  (cpu_ads_i),
        .win_ok_o   (win_ok)
    );

    snp_burst #(
        .AW    (AW),
        .LINE_W(LINE_W),
        .BEATS (BEATS)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .cpu_ads_i (cpu_ads_i),
        .cpu_wbk_i (cpu_wbk_i),
        .ads_line_i(cpu_addr_i[AW-1:LINE_W]),
        .cpu_brdy_i(cpu_brdy_i),
        .run_o     (wb_run),
        .last_o    (wb_last),
        .line_o    (wb_line)
    );

    always_comb begin
        d        = q;
        free_now = (q.state == ST_IDLE) || ((q.state == ST_DRAIN) && !cpu_hitm_i);
        eads_o   = mst_ads_i & win_ok & free_now;
        line_hit = wb_run && (mst_addr_i[AW-1:LINE_W] == wb_line);

        unique case (q.state)
            ST_LOOK: begin
                if (!ahold_i) d.kept = 1'b0;
                if (q.cnt == LAST_CNT) begin
                    if (cpu_hitm_i) begin
                        if (q.joined) begin
                            d.state = (wb_run && !wb_last) ? ST_JOIN : ST_DRAIN;
                        end else begin
                            d.state = ST_WAIT_ADS;
                        end
                    end else begin
                        d.state  = ST_IDLE;
                        d.joined = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT_ADS: begin
                if (cpu_ads_i) begin
                    d.use_cp = q.kept & ahold_i;
                    d.state  = ST_BURST;
                end
                if (!ahold_i) d.kept = 1'b0;
            end
            ST_BURST: begin
                if (wb_last) begin
                    d.state  = ST_DRAIN;
                    d.use_cp = 1'b0;
                end
            end
            ST_JOIN: begin
                if (wb_last || !wb_run) d.state = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!cpu_hitm_i) begin
                    d.state  = ST_IDLE;
                    d.joined = 1'b0;
                end
            end
            default: ;
        endcase

        if (eads_o) begin
            d.state    = ST_LOOK;
            d.cnt      = '0;
            d.inq_addr = mst_addr_i;
            d.kept     = ahold_i;
            d.use_cp   = 1'b0;
            d.joined   = line_hit;
        end

        if (cpu_ads_i && cpu_btm_i) begin
            d.btm = cpu_addr_i[AW-1:3];
        end

        wb_latched_o = ((q.state == ST_WAIT_ADS) && q.kept && ahold_i)
                     || ((q.state == ST_BURST) && q.use_cp);
        wb_addr_o    = wb_latched_o ? q.inq_addr : cpu_addr_i;
        busy_o       = (q.state != ST_IDLE);
        join_o       = q.joined;
        btm_addr_o   = q.btm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/snp_inquire_chk.sv
module snp_inquire_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mst_ads_i,
    input logic [AW-1:0] mst_addr_i,
    input logic          hold_i,
    input logic          ahold_i,
    input logic          cpu_reset_i,
    input logic          cpu_init_i,
    input logic          cpu_ads_i,
    input logic          cpu_btm_i,
    input logic [AW-1:0] cpu_addr_i,
    input logic          cpu_hitm_i,
    input logic          eads_o,
    input logic          busy_o,
    input logic          wb_latched_o,
    input logic [AW-1:0] wb_addr_o,
    input logic [AW-4:0] btm_addr_o
);

    logic          hold_q1;
    logic          hold_q2;
    logic [AW-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q1 <= 1'b0;
            hold_q2 <= 1'b0;
            cap_q   <= '0;
        end else begin
            hold_q1 <= hold_i;
            hold_q2 <= hold_q1;
            if (eads_o) cap_q <= mst_addr_i;
        end
    end

    assert_window_R1: assert property (@(posedge clk) disable iff (rst)
        eads_o |-> (mst_ads_i && (ahold_i || hold_i || hold_q1)));

    assert_after_release_R1: assert property (@(posedge clk) disable iff (rst)
        (hold_q2 && !hold_q1 && !hold_i) |-> !eads_o);

    assert_latched_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (wb_latched_o && cpu_ads_i) |-> (ahold_i && (wb_addr_o == cap_q)));

    assert_idle_no_copy_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !wb_latched_o);

    assert_single_inquire_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cpu_hitm_i) |-> !eads_o);

    assert_btm_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ads_i && cpu_btm_i) |=> (btm_addr_o == $past(cpu_addr_i[AW-1:3])));

    assert_bist_block_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(cpu_reset_i) && cpu_init_i) |=> !eads_o);

endmodule

bind snp_inquire_ctrl snp_inquire_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_snp_inquire_ctrl.sv
module tb_snp_inquire_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mst_ads_i = 1'b0;
    logic [AW-1:0] mst_addr_i = '0;
    logic          hold_i = 1'b0;
    logic          ahold_i = 1'b0;
    logic          cpu_reset_i = 1'b0;
    logic          cpu_init_i = 1'b0;
    logic          cpu_ads_i = 1'b0;
    logic          cpu_wbk_i = 1'b0;
    logic          cpu_btm_i = 1'b0;
    logic [AW-1:0] cpu_addr_i = '0;
    logic          cpu_brdy_i = 1'b0;
    logic          cpu_hitm_i = 1'b0;
    logic          eads_o;
    logic          busy_o;
    logic          join_o;
    logic          wb_latched_o;
    logic [AW-1:0] wb_addr_o;
    logic [AW-4:0] btm_addr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        int          sig;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    snp_inquire_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .mst_ads_i   (mst_ads_i),
        .mst_addr_i  (mst_addr_i),
        .hold_i      (hold_i),
        .ahold_i     (ahold_i),
        .cpu_reset_i (cpu_reset_i),
        .cpu_init_i  (cpu_init_i),
        .cpu_ads_i   (cpu_ads_i),
        .cpu_wbk_i   (cpu_wbk_i),
        .cpu_btm_i   (cpu_btm_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_brdy_i  (cpu_brdy_i),
        .cpu_hitm_i  (cpu_hitm_i),
        .eads_o      (eads_o),
        .busy_o      (busy_o),
        .join_o      (join_o),
        .wb_latched_o(wb_latched_o),
        .wb_addr_o   (wb_addr_o),
        .btm_addr_o  (btm_addr_o)
    );

    function automatic logic [31:0] sample(int sig);
        case (sig)
            0:       return {31'd0, eads_o};
            1:       return {31'd0, busy_o};
            2:       return {31'd0, join_o};
            3:       return {31'd0, wb_latched_o};
            4:       return wb_addr_o;
            default: return {3'd0, btm_addr_o};
        endcase
    endfunction

    task automatic expect_item(string tag, int sig, logic [31:0] exp);
        item_t it;
        it.tag = tag;
        it.sig = sig;
        it.exp = exp;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = sample(it.sig);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sig%0d actual %h expected %h", it.tag, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        mst_ads_i  = 1'b0;
        cpu_ads_i  = 1'b0;
        cpu_wbk_i  = 1'b0;
        cpu_btm_i  = 1'b0;
        cpu_brdy_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        expect_item("R9", 1, 0);
        expect_item("R9", 0, 0);
        expect_item("R9", 2, 0);
        expect_item("R9", 3, 0);
        expect_item("R9", 5, 0);

        // R1: no hold of any kind
        step(); mst_ads_i = 1; mst_addr_i = 32'h0000_1000; #1;
        expect_item("R1", 0, 0);

        // R2 and R4: address-hold kept, modified hit
        step(); ahold_i = 1; mst_ads_i = 1; mst_addr_i = 32'h0000_1240; #1;
        expect_item("R1", 0, 1);
        step(); #1; expect_item("R4", 1, 1);
        step(); cpu_hitm_i = 1;
        step(); cpu_ads_i = 1; cpu_wbk_i = 1; cpu_addr_i = 32'hDEAD_0000; #1;
        expect_item("R2", 3, 1);
        expect_item("R2", 4, 32'h0000_1240);
        step(); cpu_brdy_i = 1; cpu_addr_i = 32'h5555_0000; #1;
        expect_item("R2", 4, 32'h0000_1240);
        step(); cpu_brdy_i = 1;
        step(); cpu_brdy_i = 1;
        step(); cpu_brdy_i = 1; mst_ads_i = 1; mst_addr_i = 32'h0000_2000; #1;
        expect_item("R4", 0, 0);
        step(); cpu_hitm_i = 0; mst_ads_i = 1; mst_addr_i = 32'h0000_2000; #1;
        expect_item("R4", 0, 1);
        step();
        step(); #1; expect_item("R5", 1, 1);
        step(); #1; expect_item("R5", 1, 0);

        // R3: address-hold dropped before the write-back strobe
        step(); mst_ads_i = 1; mst_addr_i = 32'h0000_3308; #1;
        expect_item("R1", 0, 1);
        step();
        step(); cpu_hitm_i = 1;
        step(); ahold_i = 0;
        step(); cpu_ads_i = 1; cpu_wbk_i = 1; cpu_addr_i = 32'h0000_3300; #1;
        expect_item("R3", 3, 0);
        expect_item("R3", 4, 32'h0000_3300);
        repeat (4) begin step(); cpu_brdy_i = 1; end
        step(); cpu_hitm_i = 0;
        step(); #1; expect_item("R3", 1, 0);
        expect_item("R3", 3, 0);

        // R1: HOLD held, then the release clock
        step(); hold_i = 1;
        step(); mst_ads_i = 1; mst_addr_i = 32'h0000_5000; #1;
        expect_item("R1", 0, 1);
        step(); step(); step();
        step(); hold_i = 0; mst_ads_i = 1; mst_addr_i = 32'h0000_5100; #1;
        expect_item("R1", 0, 1);
        step(); step(); step();
        // R1: clock after a release is rejected
        step(); hold_i = 1;
        step();
        step(); hold_i = 0;
        step(); ahold_i = 1; mst_ads_i = 1; mst_addr_i = 32'h0000_5200; #1;
        expect_item("R1", 0, 0);
        step(); mst_ads_i = 1; mst_addr_i = 32'h0000_5200; #1;
        expect_item("R1", 0, 1);
        step(); step(); step(); ahold_i = 0;
        #1; expect_item("R5", 1, 0);

        // R6: inquire hits a running replacement write-back
        step(); cpu_ads_i = 1; cpu_wbk_i = 1; cpu_addr_i = 32'h0000_4400;
        step(); cpu_brdy_i = 1; ahold_i = 1; mst_ads_i = 1; mst_addr_i = 32'h0000_4408; #1;
        expect_item("R6", 0, 1);
        step(); cpu_brdy_i = 1; #1;
        expect_item("R6", 2, 1);
        step(); cpu_brdy_i = 1; cpu_hitm_i = 1;
        step(); cpu_brdy_i = 1; #1;
        expect_item("R6", 3, 0);
        step(); cpu_hitm_i = 0; #1;
        expect_item("R6", 1, 1);
        step(); #1;
        expect_item("R6", 1, 0);
        expect_item("R6", 2, 0);

        // R7: branch-trace capture
        step(); ahold_i = 0; cpu_ads_i = 1; cpu_btm_i = 1; cpu_addr_i = 32'hABCD_EF78;
        step(); #1; expect_item("R7", 5, 32'hABCD_EF78 >> 3);
        step(); cpu_ads_i = 1; cpu_addr_i = 32'h1111_1110;
        step(); #1; expect_item("R7", 5, 32'hABCD_EF78 >> 3);

        // R8: self-test blocks inquires until first strobe
        step(); cpu_reset_i = 1; cpu_init_i = 1;
        step();
        step(); cpu_reset_i = 0;
        step(); cpu_init_i = 0; ahold_i = 1; mst_ads_i = 1; mst_addr_i = 32'h0000_6000; #1;
        expect_item("R8", 0, 0);
        step(); cpu_ads_i = 1; cpu_addr_i = 32'hFFFF_FFF0;
        step(); mst_ads_i = 1; mst_addr_i = 32'h0000_6000; #1;
        expect_item("R8", 0, 1);
        step(); step(); step(); ahold_i = 0;
        #1; expect_item("R8", 1, 0);

        step(); step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule